// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the combinational arithmetic and logic stage of a 32-bit load/store processor core. In one pass it takes a first operand and a second operand, and computes a result, a destination write enable, and the next negative, zero, carry and overflow flags. The second operand has already been through the barrel shifter, and the shifter's carry-out arrives with it. The operation comes from a 4-bit opcode. A separate set-flags input decides whether flags change for the operations that produce a result. Four probe operations always update the flags and never write a register.

The surrounding pipeline handles operand shifting, condition evaluation, register-file access and cycle timing. It presents the current flags on `flags_in`. It writes back `flags_out` and, when `rd_we` is high, `result`.

Top module: `dp_alu`

## Requirements
- R1: Logical opcodes write these results: 0 gives `a & b`, 1 gives `a ^ b`, 12 gives `a | b`, 13 gives `b`, 14 gives `a & ~b` and 15 gives `~b`.
- R2: Arithmetic opcodes write these results, all modulo 2^32, where C is `flags_in[1]`: 4 gives `a + b`, 5 gives `a + b + C`, 2 gives `a - b`, 6 gives `a - b + C - 1`, 3 gives `b - a` and 7 gives `b - a + C - 1`.
- R3: When flags update on an arithmetic or compare opcode, C is the unsigned carry-out of the addition, which is the not-borrow for subtraction (1 when no borrow occurs). V is set on two's-complement signed overflow.
- R4: When flags update, N equals bit 31 of the computed value and Z is 1 exactly when the computed value is zero. For logical and test opcodes, V keeps `flags_in[0]`. The flags are packed as bit 3 N, bit 2 Z, bit 1 C and bit 0 V on both `flags_in` and `flags_out`.
- R5: When flags update on a logical or test opcode, C takes `shift_cout` if `shift_nonzero` is 1. Otherwise C keeps `flags_in[1]`.
- R6: Opcodes 8 (test, AND), 9 (equivalence test, XOR), 10 (compare, `a - b`) and 11 (negative compare, `a + b`) drive `rd_we` low and update the flags whatever `set_flags` is.
- R7: All opcodes other than 8 to 11 drive `rd_we` high.
- R8: When `set_flags` is 0 and the opcode is not 8 to 11, `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, after the shifter |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Flag update enable for result-writing operations |
| shift_cout | input | 1 | Carry-out of the shifter |
| shift_nonzero | input | 1 | Shift amount was non-zero |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Computed value |
| rd_we | output | 1 | Destination register write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
Every opcode is run against a set of operand patterns:
- zeros
- all-ones
- both extreme signed values
- equal operands
- pairs one apart
- random words

Extreme and adjacent operands separate carry from overflow, and borrow from no borrow, in both subtraction orders. Equal operands reach the zero flag through subtraction.

Each pattern is repeated with `set_flags`, `shift_nonzero`, `shift_cout` and the incoming flags toggled. This tells the held flags apart from the shifter carry and the ALU carry. It also shows whether V is held or recomputed, and whether the probe operations ignore `set_flags`.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_EOR = 4'd1,
    OP_SUB = 4'd2,
    OP_RSB = 4'd3,
    OP_ADD = 4'd4,
    OP_ADC = 4'd5,
    OP_SBC = 4'd6,
    OP_RSC = 4'd7,
    OP_TST = 4'd8,
    OP_TEQ = 4'd9,
    OP_CMP = 4'd10,
    OP_CMN = 4'd11,
    OP_ORR = 4'd12,
    OP_MOV = 4'd13,
    OP_BIC = 4'd14,
    OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  // Operations whose value comes from the adder
  function automatic logic op_is_arith(input alu_op_e op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                       OP_CMP, OP_CMN});
  endfunction

  // Flag-only operations: never write a register
  function automatic logic op_is_probe(input alu_op_e op);
    return (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
  endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end

endmodule

// File: rtl/alu_add_unit.sv
module alu_add_unit
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam int unsigned WX = W + 1;

  logic [W-1:0]  x_opnd;
  logic [W-1:0]  y_opnd;
  logic          carry_in;
  logic [WX-1:0] wide;

  // Every form reduces to x + y + carry_in, with subtraction done as
  // inverted operand plus one (or plus the incoming carry).
  always_comb begin
    unique case (op)
      OP_ADD, OP_CMN: begin x_opnd = a; y_opnd = b;  carry_in = 1'b0; end
      OP_ADC:         begin x_opnd = a; y_opnd = b;  carry_in = cin;  end
      OP_SUB, OP_CMP: begin x_opnd = a; y_opnd = ~b; carry_in = 1'b1; end
      OP_SBC:         begin x_opnd = a; y_opnd = ~b; carry_in = cin;  end
      OP_RSB:         begin x_opnd = b; y_opnd = ~a; carry_in = 1'b1; end
      OP_RSC:         begin x_opnd = b; y_opnd = ~a; carry_in = cin;  end
      default:        begin x_opnd = a; y_opnd = b;  carry_in = 1'b0; end
    endcase
  end

  always_comb begin
    wide = {1'b0, x_opnd} + {1'b0, y_opnd} + {{W{1'b0}}, carry_in};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x_opnd[W-1] == y_opnd[W-1]) && (wide[W-1] != x_opnd[W-1]);
  end

  // R3: an unsigned add that carries out must wrap below its first operand
  always_comb begin
    if (op == OP_ADD && cout) begin
      a_r3_add_wrap: assert (sum < a)
        else $error("add carry without wrap");
    end
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e      op,
  input  logic         set_flags,
  input  logic [W-1:0] value,
  input  logic         add_cout,
  input  logic         add_ovf,
  input  logic         shift_cout,
  input  logic         shift_nonzero,
  input  alu_flags_t   flags_in,
  output alu_flags_t   flags_out,
  output logic         rd_we
);

  logic update;
  logic arith;

  always_comb begin
    arith     = op_is_arith(op);
    update    = op_is_probe(op) || set_flags;
    rd_we     = !op_is_probe(op);
    flags_out = flags_in;
    if (update) begin
      flags_out.n = value[W-1];
      flags_out.z = (value == '0);
      if (arith) begin
        flags_out.c = add_cout;
        flags_out.v = add_ovf;
      end else begin
        flags_out.c = shift_nonzero ? shift_cout : flags_in.c;
      end
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  input  logic         shift_cout,
  input  logic         shift_nonzero,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic         rd_we,
  output logic [3:0]   flags_out
);

  alu_op_e     op;
  alu_flags_t  fin;
  alu_flags_t  fout;
  logic [W-1:0] logic_y;
  logic [W-1:0] add_y;
  logic        add_c;
  logic        add_v;

  assign op  = alu_op_e'(opcode);
  assign fin = alu_flags_t'(flags_in);

  alu_logic_unit #(.W(W)) u_logic (
    .a  (op_a),
    .b  (op_b),
    .op (op),
    .y  (logic_y)
  );

  alu_add_unit #(.W(W)) u_add (
    .a    (op_a),
    .b    (op_b),
    .op   (op),
    .cin  (fin.c),
    .sum  (add_y),
    .cout (add_c),
    .ovf  (add_v)
  );

  always_comb begin
    result = op_is_arith(op) ? add_y : logic_y;
  end

  alu_flag_unit #(.W(W)) u_flags (
    .op            (op),
    .set_flags     (set_flags),
    .value         (result),
    .add_cout      (add_c),
    .add_ovf       (add_v),
    .shift_cout    (shift_cout),
    .shift_nonzero (shift_nonzero),
    .flags_in      (fin),
    .flags_out     (fout),
    .rd_we         (rd_we)
  );

  assign flags_out = fout;

  always_comb begin
    // R8: writing op without set-flags keeps every flag
    if (rd_we && !set_flags) begin
      a_r8_hold_flags: assert (flags_out == flags_in)
        else $error("flags changed without set-flags");
    end
    // R6: probe opcodes never write the destination
    if (opcode[3:2] == 2'b10) begin
      a_r6_no_write: assert (!rd_we)
        else $error("probe opcode wrote a register");
    end
    // R4: zero flag tracks the computed value when flags update
    if (set_flags || !rd_we) begin
      a_r4_zero_flag: assert (flags_out[2] == (result == '0))
        else $error("zero flag mismatch");
    end
    // R5: logical op without a shift keeps the carry
    if ((set_flags || !rd_we) && !op_is_arith(op) && !shift_nonzero) begin
      a_r5_keep_carry: assert (flags_out[1] == flags_in[1])
        else $error("logical carry changed without shift");
    end
    // R4: logical op keeps the overflow flag
    if (!op_is_arith(op)) begin
      a_r4_keep_v: assert (flags_out[0] == flags_in[0])
        else $error("logical op changed V");
    end
  end

endmodule

// File: tb/tb_dp_alu.sv
`timescale 1ns/1ps
module tb_dp_alu;

  logic clk;
  logic [31:0] op_a, op_b;
  logic [3:0]  opcode;
  logic        set_flags, shift_cout, shift_nonzero;
  logic [3:0]  flags_in;
  logic [31:0] result;
  logic        rd_we;
  logic [3:0]  flags_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  dp_alu dut (
    .op_a(op_a), .op_b(op_b), .opcode(opcode), .set_flags(set_flags),
    .shift_cout(shift_cout), .shift_nonzero(shift_nonzero),
    .flags_in(flags_in), .result(result), .rd_we(rd_we),
    .flags_out(flags_out)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s op=%0d a=%h b=%h: actual %h expected %h",
               req, what, opcode, op_a, op_b, act, exp);
    end
  endtask

  // Behavioural reference: integers, no adder structure
  task automatic run(input logic [31:0] a, input logic [31:0] b,
                     input logic [3:0] op, input logic s, input logic sc,
                     input logic snz, input logic [3:0] fi);
    longint unsigned ua, ub, cy, r64;
    longint sa, sb, sr;
    logic [31:0] er;
    logic en, ez, ec, ev, we, upd, arith, probe;
    @(posedge clk);
    op_a = a; op_b = b; opcode = op; set_flags = s;
    shift_cout = sc; shift_nonzero = snz; flags_in = fi;
    ua = longint'(a); ub = longint'(b); cy = longint'(fi[1]);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ec = fi[1]; ev = fi[0]; arith = 1; sr = 0; er = 0;
    case (op)
      4'd4, 4'd11: begin r64 = ua + ub;        sr = sa + sb;        ec = (r64 >> 32) != 0; end
      4'd5:        begin r64 = ua + ub + cy;   sr = sa + sb + longint'(cy); ec = (r64 >> 32) != 0; end
      4'd2, 4'd10: begin r64 = ua - ub;        sr = sa - sb;        ec = (ua >= ub); end
      4'd6:        begin r64 = ua - ub - (1 - cy); sr = sa - sb - longint'(1 - cy); ec = (ua >= ub + 1 - cy); end
      4'd3:        begin r64 = ub - ua;        sr = sb - sa;        ec = (ub >= ua); end
      4'd7:        begin r64 = ub - ua - (1 - cy); sr = sb - sa - longint'(1 - cy); ec = (ub >= ua + 1 - cy); end
      default: begin
        arith = 0;
        case (op)
          4'd0, 4'd8: er = a & b;
          4'd1, 4'd9: er = a ^ b;
          4'd12:      er = a | b;
          4'd13:      er = b;
          4'd14:      er = a & ~b;
          default:    er = ~b;
        endcase
        r64 = longint'(er);
        if (snz) ec = sc;
      end
    endcase
    if (arith) begin
      er = r64[31:0];
      ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end
    probe = (op >= 4'd8 && op <= 4'd11);
    we  = !probe;
    upd = probe || s;
    en = er[31]; ez = (er == 0);
    @(negedge clk);
    chk(probe ? "R6" : "R7", "rd_we", {31'b0, rd_we}, {31'b0, we});
    if (!probe) chk(arith ? "R2" : "R1", "result", result, er);
    if (!upd) chk("R8", "flags", {28'b0, flags_out}, {28'b0, fi});
    else if (arith) begin
      chk(probe ? "R6" : "R4", "NZ", {30'b0, flags_out[3:2]}, {30'b0, en, ez});
      chk("R3", "CV", {30'b0, flags_out[1:0]}, {30'b0, ec, ev});
    end else begin
      chk(probe ? "R6" : "R4", "NZV", {29'b0, flags_out[3:2], flags_out[0]},
          {29'b0, en, ez, fi[0]});
      chk("R5", "C", {31'b0, flags_out[1]}, {31'b0, ec});
    end
  endtask

  logic [31:0] pat [10];

  initial begin
    op_a = 0; op_b = 0; opcode = 0; set_flags = 0;
    shift_cout = 0; shift_nonzero = 0; flags_in = 0;
    // Idle state: all-zero inputs give AND with a write and held flags (R7, R8)
    @(negedge clk);
    chk("R7", "idle rd_we", {31'b0, rd_we}, 32'd1);
    chk("R8", "idle flags", {28'b0, flags_out}, 32'd0);

    pat[0] = 32'h0000_0000; pat[1] = 32'hFFFF_FFFF; pat[2] = 32'h7FFF_FFFF;
    pat[3] = 32'h8000_0000; pat[4] = 32'h0000_0001; pat[5] = 32'h8000_0001;
    pat[6] = 32'h7FFF_FFFE; pat[7] = 32'h1234_5678; pat[8] = 32'hF0F0_0F0F;
    pat[9] = 32'h0000_0002;

    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          for (int m = 0; m < 4; m++)
            run(pat[i], pat[j], 4'(op), m[0], m[1], m[1] ^ m[0],
                4'((i * 3 + j + m * 5) & 15));

    for (int k = 0; k < 3000; k++)
      run($urandom, $urandom, 4'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 4'($urandom));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule